// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block drives a 16-bit successive-approximation converter over a four-wire serial link: a conversion-start line, a serial clock, a serial result input and a serial configuration output. It runs from a fast system clock. While enabled, it starts a conversion on a fixed throughput period. It holds the start line high for a short pulse. It then waits out the worst-case conversion time, and then runs one burst of serial clocks. That burst shifts a 14-bit configuration word out MSB first and gathers the 16-bit result MSB first.

Every timing limit is a clock-count parameter: the throughput period, the conversion wait, the start-pulse width and the serial half-period. The serial output changes only on serial-clock falls, so the converter can sample it on rises. The converter's result line is captured on the system clock edge that raises the serial clock. That edge comes one half-period after the converter last moved the line. The finished word appears on a result port with a one-clock strobe.

Dropping the enable stops the link at once. The internal period still runs out before any new conversion can start, so the minimum spacing between conversions holds through any enable pattern.

Top module: `sar_seq_ctrl`

## Requirements
- R1: During and after reset, with enable low, cnv_o, sck_o, din_o and valid_o are 0 and result_o is all zeros.
- R2: While en_i is low no conversion starts. If en_i is sampled low mid-period, cnv_o and sck_o are low from the second clock after it and stay low for the rest of that period. The abandoned period produces no valid_o pulse.
- R3: Successive rising edges of cnv_o are never fewer than CYC_CLKS clocks apart. While en_i stays high they are exactly CYC_CLKS clocks apart, and a new period begins only when the previous one has run out.
- R4: cnv_o is high for CNVH_CLKS clocks at the start of every period.
- R5: The first sck_o rise comes exactly CONV_CLKS clocks after the cnv_o rise. It is followed by RES_W pulses in all, each high for HALF_CLKS clocks and low for HALF_CLKS clocks. sck_o and cnv_o are never high together.
- R6: din_o carries the latched configuration MSB first. Bit k (k = 0 for the MSB) is on din_o at the k-th sck_o rise. din_o changes only on clocks where sck_o falls, and it is 0 once all CFG_W bits are out.
- R7: The configuration is latched from cfg_i on the clock that raises cnv_o. Later changes to cfg_i do not affect the word sent in that period.
- R8: sdo_i is sampled on each clock where sck_o rises, and the first sample is the MSB. result_o is the RES_W samples in order, and it holds until the next completed period.
- R9: valid_o is high for exactly one clock, starting with the clock of the last sck_o rise of the period, and result_o is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable for periodic conversions |
| cfg_i | input | CFG_W | Configuration word to send each period |
| sdo_i | input | 1 | Serial result line from the converter |
| cnv_o | output | 1 | Conversion start, rising edge starts a conversion |
| sck_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial configuration line to the converter |
| result_o | output | RES_W | Last captured conversion result |
| valid_o | output | 1 | One-clock strobe marking a new result |

## Verification
The assertions take en_i and cfg_i to be synchronous to clk. They also take sdo_i to move only after sck_o falls, and the parameters to leave room for the pulse, the wait and the full burst inside one period (CNVH_CLKS < CONV_CLKS and CONV_CLKS + 2·HALF_CLKS·RES_W < CYC_CLKS). The stimulus drives en_i and cfg_i on the falling system-clock edge. Its converter model moves sdo_i one nanosecond after each sck_o fall and each cnv_o fall. Enable drops are placed inside the conversion wait and inside the serial burst, and configuration changes are placed in mid-period.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // period state of the conversion time base
    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_RUN   = 2'd1,
        TM_DRAIN = 2'd2
    } tmode_e;

    // bits needed to hold values 0 .. n-1, at least one
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
    import sar_seq_pkg::*;
#(
    parameter int unsigned CYC_CLKS = 500,
    parameter int unsigned CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             act_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_CLKS - 1);

    typedef struct packed {
        tmode_e           mode;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            TM_IDLE: begin
                if (en_i) begin
                    st_d.mode = TM_RUN;
                    st_d.cnt  = '0;
                end
            end
            default: begin
                if (st_q.cnt == LAST) begin
                    st_d.cnt  = '0;
                    st_d.mode = en_i ? TM_RUN : TM_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.mode == TM_RUN && !en_i) begin
                        st_d.mode = TM_DRAIN;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: TM_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign act_o = (st_q.mode == TM_RUN);

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == TM_DRAIN && st_q.cnt != LAST) |=> (st_q.mode == TM_DRAIN));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/sar_seq_sclk.sv
module sar_seq_sclk
    import sar_seq_pkg::*;
#(
    parameter int unsigned CONV_CLKS = 320,
    parameter int unsigned HALF_CLKS = 2,
    parameter int unsigned NBITS     = 16,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             act_i,
    output logic             sck_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             last_o
);

    localparam int unsigned PER  = 2 * HALF_CLKS;
    localparam int unsigned HC_W = cnt_bits(PER);
    localparam int unsigned BI_W = cnt_bits(NBITS);
    localparam logic [CNT_W-1:0] START   = CNT_W'(CONV_CLKS);
    localparam logic [HC_W-1:0]  HC_LAST = HC_W'(PER - 1);
    localparam logic [HC_W-1:0]  HC_HALF = HC_W'(HALF_CLKS);
    localparam logic [BI_W-1:0]  BI_LAST = BI_W'(NBITS - 1);

    typedef struct packed {
        logic            ph;
        logic [HC_W-1:0] hc;
        logic [BI_W-1:0] bi;
        logic            sck;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!act_i) begin
            st_d.ph = 1'b0;
            st_d.hc = '0;
            st_d.bi = '0;
        end else if (cnt_i == START) begin
            st_d.ph = 1'b1;
            st_d.hc = '0;
            st_d.bi = '0;
        end else if (st_q.ph) begin
            if (st_q.hc == HC_LAST) begin
                st_d.hc = '0;
                if (st_q.bi == BI_LAST) begin
                    st_d.ph = 1'b0;
                end else begin
                    st_d.bi = st_q.bi + 1'b1;
                end
            end else begin
                st_d.hc = st_q.hc + 1'b1;
            end
        end
        st_d.sck = st_d.ph && (st_d.hc < HC_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o  = st_q.sck;
    assign rise_o = st_d.sck && !st_q.sck;
    assign fall_o = !st_d.sck && st_q.sck;
    assign last_o = rise_o && (st_d.bi == BI_LAST);

    // checker state: length of the current high run of the serial clock
    logic [HC_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (st_q.sck) begin
            hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
        end
    end

    // R5
    sck_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.sck) && act_i) |-> (hi_run_q == (HC_W + 1)'(HALF_CLKS)));

endmodule

// File: rtl/sar_seq_shift.sv
module sar_seq_shift #(
    parameter int unsigned RES_W = 16,
    parameter int unsigned CFG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sdo_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             last_i,
    output logic             din_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [CFG_W-1:0] tx;
        logic [RES_W-1:0] rx;
        logic [RES_W-1:0] res;
        logic             vld;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!act_i) begin
            st_d.tx = '0;
        end else if (load_i) begin
            st_d.tx = cfg_i;
            st_d.rx = '0;
        end else if (fall_i) begin
            st_d.tx = {st_q.tx[CFG_W-2:0], 1'b0};
        end
        if (rise_i) begin
            st_d.rx = {st_q.rx[RES_W-2:0], sdo_i};
            if (last_i) begin
                st_d.res = {st_q.rx[RES_W-2:0], sdo_i};
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign din_o    = st_q.tx[CFG_W-1];
    assign result_o = st_q.res;
    assign valid_o  = st_q.vld;

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> $stable(st_q.res));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned CYC_CLKS  = 500,
    parameter int unsigned CONV_CLKS = 320,
    parameter int unsigned CNVH_CLKS = 2,
    parameter int unsigned HALF_CLKS = 2,
    parameter int unsigned RES_W     = 16,
    parameter int unsigned CFG_W     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sdo_i,
    output logic             cnv_o,
    output logic             sck_o,
    output logic             din_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o
);

    localparam int unsigned CNT_W = cnt_bits(CYC_CLKS + 1);
    localparam logic [CNT_W-1:0] CNVH_END = CNT_W'(CNVH_CLKS);
    localparam logic [CNT_W-1:0] GAP_MAX  = CNT_W'(CYC_CLKS);

    logic [CNT_W-1:0] t_cnt;
    logic             t_act;
    logic             sck_rise, sck_fall, sck_last;

    typedef struct packed {
        logic cnv;
    } top_st_t;

    top_st_t st_d, st_q;

    sar_seq_timer #(
        .CYC_CLKS (CYC_CLKS),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .cnt_o (t_cnt),
        .act_o (t_act)
    );

    sar_seq_sclk #(
        .CONV_CLKS (CONV_CLKS),
        .HALF_CLKS (HALF_CLKS),
        .NBITS     (RES_W),
        .CNT_W     (CNT_W)
    ) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (t_cnt),
        .act_i  (t_act),
        .sck_o  (sck_o),
        .rise_o (sck_rise),
        .fall_o (sck_fall),
        .last_o (sck_last)
    );

    sar_seq_shift #(
        .RES_W (RES_W),
        .CFG_W (CFG_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (t_act),
        .load_i   (t_act && (t_cnt == '0)),
        .cfg_i    (cfg_i),
        .sdo_i    (sdo_i),
        .rise_i   (sck_rise),
        .fall_i   (sck_fall),
        .last_i   (sck_last),
        .din_o    (din_o),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnv = t_act && (t_cnt < CNVH_END);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnv_o = st_q.cnv;

    // checker state: clocks since the last conversion start, saturating
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_MAX;
        end else if (st_d.cnv && !st_q.cnv) begin
            gap_q <= '0;
        end else if (gap_q < GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3
    cnv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.cnv && !st_q.cnv) |-> (gap_q >= CNT_W'(CYC_CLKS - 1)));

    // R5
    sck_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |-> (gap_q >= CNT_W'(CONV_CLKS - 1)));

    // R5
    cnv_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnv_o && sck_o));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !$past(en_i)) |=> (!cnv_o && !sck_o));

    // R6
    din_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(din_o));

endmodule

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;

    localparam int CYC  = 500;
    localparam int CONV = 320;
    localparam int CNVH = 2;
    localparam int HALF = 2;
    localparam int RW   = 16;
    localparam int CW   = 14;
    localparam int PER  = 2 * HALF;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          en    = 1'b0;
    logic          sdo   = 1'b0;
    logic [CW-1:0] cfg   = '0;
    logic          cnv, sck, din, vld;
    logic [RW-1:0] res;

    always #2.5 clk = ~clk;

    sar_seq_ctrl #(
        .CYC_CLKS (CYC), .CONV_CLKS (CONV), .CNVH_CLKS (CNVH),
        .HALF_CLKS (HALF), .RES_W (RW), .CFG_W (CW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .en_i (en), .cfg_i (cfg), .sdo_i (sdo),
        .cnv_o (cnv), .sck_o (sck), .din_o (din), .result_o (res), .valid_o (vld)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (clock %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc++;

    // behavioural reference: position within the period, -1 when idle
    int            m_pos   = -1;
    bit            m_drain = 1'b0;
    logic [CW-1:0] m_cfg   = '0;
    bit exp_cnv = 0, exp_sck = 0, exp_din = 0, exp_vld = 0;

    always @(posedge clk) begin
        int p, rel, f;
        bit live;
        if (!rst_n) begin
            m_pos = -1; m_drain = 0; m_cfg = '0;
            exp_cnv = 0; exp_sck = 0; exp_din = 0; exp_vld = 0;
        end else begin
            p    = m_pos;
            live = (p >= 0) && !m_drain;
            rel  = p - CONV;
            if (live && p == 0) m_cfg = cfg;
            exp_cnv = live && (p < CNVH);
            exp_sck = live && rel >= 0 && rel < RW * PER && (rel % PER) < HALF;
            f = (rel < HALF) ? 0 : (rel - HALF) / PER + 1;
            exp_din = live && (f < CW) ? m_cfg[CW-1-f] : 1'b0;
            exp_vld = live && (rel == (RW - 1) * PER);
            if (p < 0) begin
                if (en) begin m_pos = 0; m_drain = 0; end
            end else if (p == CYC - 1) begin
                m_pos = en ? 0 : -1;
                m_drain = 0;
            end else begin
                m_pos = p + 1;
                if (!en) m_drain = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(cnv === exp_cnv, "R4 cnv level", cnv, exp_cnv);
            chk(sck === exp_sck, "R5 sck level", sck, exp_sck);
            chk(din === exp_din, "R6 din level", din, exp_din);
            chk(vld === exp_vld, "R9 valid strobe", vld, exp_vld);
        end
    end

    // converter model
    logic [RW-1:0] adc_word   = '0;
    logic [CW-1:0] rx_cfg     = '0;
    logic [CW-1:0] cfg_at_cnv = '0;
    int bitp = 0, rx_n = 0, n_cnv = 0, n_vld = 0, last_rise = -1;
    int unsigned seed = 32'h1234_5678;

    always @(posedge cnv) begin
        if (n_cnv == 0)      adc_word = 16'h8001;
        else if (n_cnv == 1) adc_word = 16'hFFFF;
        else if (n_cnv == 2) adc_word = 16'h0000;
        else begin
            seed = seed * 32'd1103515245 + 32'd12345;
            adc_word = seed[23:8];
        end
        cfg_at_cnv = cfg;
        rx_n = 0;
        if (last_rise >= 0) chk((cyc - last_rise) >= CYC, "R3 cnv spacing", cyc - last_rise, CYC);
        last_rise = cyc;
        n_cnv++;
    end

    always @(negedge cnv) begin
        #1 sdo = adc_word[RW-1];
        bitp = RW - 2;
    end

    always @(negedge sck) begin
        #1;
        if (bitp >= 0) sdo = adc_word[bitp];
        bitp--;
    end

    always @(posedge sck) begin
        if (rx_n < CW) begin
            rx_cfg = {rx_cfg[CW-2:0], din};
            rx_n++;
        end
    end

    always @(negedge clk) begin
        if (vld && !done) begin
            chk(res === adc_word, "R8 result word", res, adc_word);
            chk(rx_cfg === cfg_at_cnv && rx_n == CW, "R7 config shifted on din", rx_cfg, cfg_at_cnv);
            n_vld++;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v0, c0;
        wait_clks(4);
        chk(cnv === 1'b0 && sck === 1'b0 && din === 1'b0 && vld === 1'b0, "R1 reset outputs",
            {cnv, sck, din, vld}, 0);
        chk(res === '0, "R1 reset result", res, 0);
        rst_n = 1'b1;
        wait_clks(60);
        chk(n_cnv == 0, "R2 no conversion while disabled", n_cnv, 0);

        cfg = 14'h2A5C;
        en  = 1'b1;
        wait_clks(CYC / 2);
        cfg = 14'h1337;      // R7: mid-period change
        wait_clks(3 * CYC);
        chk(n_vld >= 3, "R9 results while enabled", n_vld, 3);

        // drop enable in the middle of the serial burst
        @(posedge cnv);
        repeat (6) @(posedge sck);
        @(negedge clk);
        en = 1'b0;
        v0 = n_vld;
        wait_clks(20);
        chk(sck === 1'b0 && cnv === 1'b0, "R2 link quiet after enable drop", {cnv, sck}, 0);
        en = 1'b1;
        @(posedge cnv);
        @(negedge clk);
        chk(n_vld == v0, "R2 abandoned period gives no result", n_vld, v0);
        wait_clks(2 * CYC);

        // drop enable during the conversion wait
        @(posedge cnv);
        wait_clks(100);
        en = 1'b0;
        c0 = n_cnv;
        v0 = n_vld;
        wait_clks(2 * CYC);
        chk(n_cnv == c0, "R2 no start while disabled", n_cnv, c0);
        chk(n_vld == v0, "R2 no result after drop", n_vld, v0);
        cfg = 14'h3FFF;
        en  = 1'b1;
        wait_clks(3 * CYC);
        cfg = 14'h0001;
        wait_clks(2 * CYC);
        chk(n_vld > v0 + 3, "R9 results after re-enable", n_vld, v0 + 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #300000;
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule